// File: doc/BRIEF.md
# Local Interrupt Controller Mode Register

This block keeps the base-address and operating-mode register of a local interrupt controller. The controller runs in one of three modes: disabled, legacy, or extended. Each write to the register is checked against a table of allowed mode changes before it takes effect. A write that breaks a rule leaves the register as it was and sends back a one-cycle fault pulse, which the requester can turn into an exception.

An accepted write takes a new base address from the write data. The enable and extended bits then move as the transition rules allow. Turning the controller off sends a one-cycle strobe that clears the enable in the spurious-vector register elsewhere. Entering extended mode loads a 32-bit logical destination value, computed from a fixed controller ID. The register can be read back at any time as a 64-bit value.

Top module: `lic_mode_reg`

## Requirements
- R1: After reset the readback is 0xFEE00800 with bit 8 equal to the bootstrap strap. The enabled flag is 1, the fault and clear strobes are 0, and the logical destination is 0.
- R2: A write with data bit 10 (extended) set is rejected when the extended-capability input is low.
- R3: A write with data bit 10 set and data bit 11 (enable) clear is rejected. The readback never shows bit 10 set while bit 11 is clear.
- R4: A write with both bits 11 and 10 set is rejected while the register is disabled (bits 11 and 10 both clear).
- R5: A write with bit 11 set and bit 10 clear is rejected while the register is in extended mode (bits 11 and 10 both set).
- R6: A rejected write leaves the readback and the logical destination unchanged. `wr_fault` is high for exactly the one cycle after that write's clock edge.
- R7: An accepted write loads readback bits 31:12 from data bits 31:12. Bit 8 keeps its value. All bits other than 31:12, 11, 10 and 8 read as zero, and the matching data bits are ignored.
- R8: An accepted write with data bit 11 clear clears readback bit 11 and bit 10 and drops `ctrl_enabled`. It also pulses `spur_en_clr` for one cycle.
- R9: An accepted write with bit 11 set and bit 10 clear, made from the disabled state, sets readback bit 11 and raises `ctrl_enabled`. It raises no strobe.
- R10: An accepted write with bits 11 and 10 set sets readback bit 10. It loads `log_dest` = ((id & 0xFFFF0) << 16) | (1 << (id & 0xF)), truncated to 32 bits.
- R11: In a cycle without a write, nothing changes and neither pulse output is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the mode register |
| wr_data | input | 64 | Write value |
| ext_cap | input | 1 | Strap: extended mode is supported |
| bsp_strap | input | 1 | Bootstrap-processor flag loaded at reset |
| ctrl_id | input | 32 | Fixed initial controller ID |
| rd_value | output | 64 | Current register contents |
| wr_fault | output | 1 | One-cycle pulse for a rejected write |
| ctrl_enabled | output | 1 | Controller is enabled |
| spur_en_clr | output | 1 | One-cycle strobe that clears the spurious-vector enable |
| log_dest | output | 32 | Logical destination loaded on entry to extended mode |

## Verification
A wrong mode state shows at the ports on the cycle after the write. If the enable or extended bit is wrong, the readback shows it at once. It also changes how the next write is judged: a legal write draws a fault, or an illegal one slips through. The bench walks the controller through every mode and probes each forbidden edge from the state where it applies. Each step checks the readback, the enable flag, both pulses and the logical destination. It then checks that the pulses are gone one cycle later.

// File: rtl/lic_mode_pkg.sv
package lic_mode_pkg;
    localparam int BSP_BIT  = 8;
    localparam int EXT_BIT  = 10;
    localparam int EN_BIT   = 11;
    localparam int BASE_LO  = 12;
    localparam int BASE_HI  = 31;
    localparam int BASE_W   = BASE_HI - BASE_LO + 1;
    localparam int LDR_W    = 32;
    localparam int ID_W     = 32;
    localparam int NUM_RULE = 4;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic              en;
        logic              ext;
        logic              bsp;
    } mode_reg_t;

    typedef struct packed {
        mode_reg_t         r;
        logic [LDR_W-1:0]  ldr;
        logic              fault;
        logic              sv_clr;
    } state_t;
endpackage

// File: rtl/lic_mode_legal.sv
module lic_mode_legal
    import lic_mode_pkg::*;
(
    input  logic                cur_en,
    input  logic                cur_ext,
    input  logic                new_en,
    input  logic                new_ext,
    input  logic                cap,
    output logic [NUM_RULE-1:0] viol,
    output logic                illegal
);
    always_comb begin
        // extended requested without capability
        viol[0] = new_ext && !cap;
        // extended without enable is a forbidden combination
        viol[1] = new_ext && !new_en;
        // disabled straight into extended
        viol[2] = !cur_en && !cur_ext && new_en && new_ext;
        // extended back down to legacy
        viol[3] = cur_en && cur_ext && new_en && !new_ext;
        illegal = |viol;
    end
endmodule

// File: rtl/lic_ldr_calc.sv
module lic_ldr_calc #(
    parameter int ID_W      = 32,
    parameter int LDR_W     = 32,
    parameter int SEL_W     = 4,
    parameter int CLUSTER_S = 16
) (
    input  logic [ID_W-1:0]  id,
    output logic [LDR_W-1:0] ldr
);
    localparam int NSEL = 1 << SEL_W;
    localparam int WIDE = ID_W + CLUSTER_S;

    logic [NSEL-1:0]  member;
    logic [WIDE-1:0]  cluster_wide;
    logic [ID_W-1:0]  cluster_mask;

    for (genvar g = 0; g < NSEL; g++) begin : g_member
        assign member[g] = (id[SEL_W-1:0] == g[SEL_W-1:0]);
    end

    always_comb begin
        cluster_mask = '0;
        cluster_mask[SEL_W +: CLUSTER_S] = '1;
        cluster_wide = {{CLUSTER_S{1'b0}}, id & cluster_mask} << CLUSTER_S;
        ldr = cluster_wide[LDR_W-1:0];
        ldr[NSEL-1:0] = ldr[NSEL-1:0] | member;
    end
endmodule

// File: rtl/lic_mode_reg.sv
module lic_mode_reg
    import lic_mode_pkg::*;
#(
    parameter int                DATA_W     = 64,
    parameter logic [BASE_W-1:0] RESET_BASE = 20'hFEE00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ext_cap,
    input  logic              bsp_strap,
    input  logic [ID_W-1:0]   ctrl_id,
    output logic [DATA_W-1:0] rd_value,
    output logic              wr_fault,
    output logic              ctrl_enabled,
    output logic              spur_en_clr,
    output logic [LDR_W-1:0]  log_dest
);
    state_t              st_d, st_q;
    logic                new_en, new_ext;
    logic                illegal;
    logic [NUM_RULE-1:0] viol;
    logic [LDR_W-1:0]    ldr_calc;
    logic                unused_bits;

    assign new_en  = wr_data[EN_BIT];
    assign new_ext = wr_data[EXT_BIT];

    lic_mode_legal i_legal (
        .cur_en  (st_q.r.en),
        .cur_ext (st_q.r.ext),
        .new_en  (new_en),
        .new_ext (new_ext),
        .cap     (ext_cap),
        .viol    (viol),
        .illegal (illegal)
    );

    lic_ldr_calc #(.ID_W(ID_W), .LDR_W(LDR_W)) i_ldr (
        .id  (ctrl_id),
        .ldr (ldr_calc)
    );

    always_comb begin
        st_d        = st_q;
        st_d.fault  = 1'b0;
        st_d.sv_clr = 1'b0;
        if (wr_en) begin
            if (illegal) begin
                st_d.fault = 1'b1;
            end else begin
                st_d.r.base = wr_data[BASE_HI:BASE_LO];
                st_d.r.ext  = 1'b0;
                if (!new_en) begin
                    st_d.r.en   = 1'b0;
                    st_d.sv_clr = 1'b1;
                end
                if (!st_q.r.en && new_en) begin
                    st_d.r.en = 1'b1;
                end
                if (ext_cap && new_ext) begin
                    st_d.r.ext = 1'b1;
                    st_d.ldr   = ldr_calc;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.r.base <= RESET_BASE;
            st_q.r.en   <= 1'b1;
            st_q.r.ext  <= 1'b0;
            st_q.r.bsp  <= bsp_strap;
            st_q.ldr    <= '0;
            st_q.fault  <= 1'b0;
            st_q.sv_clr <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_value                  = '0;
        rd_value[BASE_HI:BASE_LO] = st_q.r.base;
        rd_value[EN_BIT]          = st_q.r.en;
        rd_value[EXT_BIT]         = st_q.r.ext;
        rd_value[BSP_BIT]         = st_q.r.bsp;
    end

    assign wr_fault     = st_q.fault;
    assign ctrl_enabled = st_q.r.en;
    assign spur_en_clr  = st_q.sv_clr;
    assign log_dest     = st_q.ldr;
    assign unused_bits  = ^{wr_data[DATA_W-1:BASE_HI+1], wr_data[BSP_BIT:0],
                            wr_data[EXT_BIT-1], viol};
endmodule

// File: rtl/lic_mode_reg_chk.sv
module lic_mode_reg_chk
    import lic_mode_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              ext_cap,
    input logic [DATA_W-1:0] rd_value,
    input logic              wr_fault,
    input logic              ctrl_enabled,
    input logic              spur_en_clr,
    input logic [LDR_W-1:0]  log_dest
);
    // R2
    no_cap_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ext_cap && wr_data[EXT_BIT]) |=> wr_fault);

    // R3
    ext_no_en_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[EXT_BIT] && !wr_data[EN_BIT]) |=> wr_fault);

    // R3
    no_bad_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_value[EXT_BIT] |-> rd_value[EN_BIT]);

    // R4
    dis_to_ext_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_value[EN_BIT] && !rd_value[EXT_BIT] &&
         wr_data[EN_BIT] && wr_data[EXT_BIT]) |=> wr_fault);

    // R5
    ext_to_leg_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_value[EN_BIT] && rd_value[EXT_BIT] &&
         wr_data[EN_BIT] && !wr_data[EXT_BIT]) |=> wr_fault);

    // R6
    reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fault |-> ($stable(rd_value) && $stable(log_dest)));

    // R8
    clr_means_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spur_en_clr |-> (!ctrl_enabled && !wr_fault));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (!wr_fault && !spur_en_clr && $stable(rd_value) && $stable(log_dest)));
endmodule

bind lic_mode_reg lic_mode_reg_chk #(.DATA_W(DATA_W)) i_lic_mode_reg_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .ext_cap      (ext_cap),
    .rd_value     (rd_value),
    .wr_fault     (wr_fault),
    .ctrl_enabled (ctrl_enabled),
    .spur_en_clr  (spur_en_clr),
    .log_dest     (log_dest)
);

// File: tb/test_lic_mode_reg.sv
module test_lic_mode_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic        ext_cap = 1'b0;
    logic        bsp_strap = 1'b1;
    logic [31:0] ctrl_id = 32'h0001_2345;
    logic [63:0] rd_value;
    logic        wr_fault;
    logic        ctrl_enabled;
    logic        spur_en_clr;
    logic [31:0] log_dest;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [63:0] exp_rd;
    logic [31:0] exp_ldr;

    always #10 clk = ~clk;

    lic_mode_reg i_lic_mode_reg (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .ext_cap      (ext_cap),
        .bsp_strap    (bsp_strap),
        .ctrl_id      (ctrl_id),
        .rd_value     (rd_value),
        .wr_fault     (wr_fault),
        .ctrl_enabled (ctrl_enabled),
        .spur_en_clr  (spur_en_clr),
        .log_dest     (log_dest)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [63:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic expect_all(input string req, input logic f, input logic c);
        chk({req, " readback"}, rd_value, exp_rd);
        chk({req, " enabled"}, {63'b0, ctrl_enabled}, {63'b0, exp_rd[11]});
        chk({req, " fault"}, {63'b0, wr_fault}, {63'b0, f});
        chk({req, " clear strobe"}, {63'b0, spur_en_clr}, {63'b0, c});
        chk({req, " log_dest"}, {32'b0, log_dest}, {32'b0, exp_ldr});
    endtask

    task automatic quiet_cycle(input string req);
        @(negedge clk);
        expect_all(req, 1'b0, 1'b0);
    endtask

    task automatic t_reset;
        exp_rd  = 64'hFEE0_0900;
        exp_ldr = '0;
        expect_all("R1", 1'b0, 1'b0);
    endtask

    task automatic t_base_write;
        ext_cap = 1'b0;
        write_reg(64'h1234_5678_ABCD_EAFF);
        exp_rd = 64'hABCD_E900;
        expect_all("R7", 1'b0, 1'b0);
        quiet_cycle("R7 after");
    endtask

    task automatic t_reject(input string req, input logic cap, input logic [63:0] d);
        ext_cap = cap;
        write_reg(d);
        expect_all({req, " R6"}, 1'b1, 1'b0);
        quiet_cycle({req, " R6 pulse end"});
    endtask

    task automatic t_disable(input logic [63:0] d, input logic [63:0] e);
        write_reg(d);
        exp_rd = e;
        expect_all("R8", 1'b0, 1'b1);
        quiet_cycle("R8 strobe end");
    endtask

    task automatic t_enable_legacy;
        write_reg(64'hFEE0_0800);
        exp_rd = 64'hFEE0_0900;
        expect_all("R9", 1'b0, 1'b0);
    endtask

    task automatic t_enter_ext;
        ext_cap = 1'b1;
        write_reg(64'hFEE0_0C00);
        exp_rd  = 64'hFEE0_0D00;
        exp_ldr = ((ctrl_id & 32'h000F_FFF0) << 16) | (32'h1 << ctrl_id[3:0]);
        expect_all("R10", 1'b0, 1'b0);
        chk("R10 formula", {32'b0, log_dest}, {32'b0, 32'h2340_0020});
    endtask

    task automatic t_idle;
        for (int i = 0; i < 4; i++) quiet_cycle("R11");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_base_write();
        t_reject("R2", 1'b0, 64'h1111_1C00);
        t_reject("R3", 1'b1, 64'h2222_2400);
        t_disable(64'h3333_3000, 64'h3333_3100);
        t_reject("R4", 1'b1, 64'h4444_4C00);
        t_enable_legacy();
        t_enter_ext();
        t_reject("R5", 1'b1, 64'hFEE0_0800);
        t_disable(64'h5555_5000, 64'h5555_5100);
        t_idle();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule